// File: doc/BRIEF.md
# Sixteen-Pulse Serial Frame Loader

This block writes a single 16-bit frame to a serial-controlled potentiometer without a processor. A load strobe places a fixed 8-bit command (0x11) and an 8-bit tap value into a parallel-in serial-out register. The same strobe presets a down-counter to 32. A later start pulse sets a run flag. That flag drives the active-low chip select and lets the counter step down once per cycle of the free-running clock.

The least significant bit of the counter acts as the shift clock, and the serial clock is its inverse. Because 32 decrements toggle that bit 32 times, exactly 16 rising serial-clock edges reach the receiver. Each new bit appears when the serial clock falls, so it is stable when the clock rises. When every counter stage shows zero, the combined terminal count clears the run flag. Counting then stops, chip select rises, and a one-cycle completion pulse is issued.

The counter is a chain of narrow stages. A higher stage steps down only when all lower stages show zero.

Top module: `dcp_frame_loader`

## Requirements
- R1: After reset, and whenever no frame is active, `cs_n` = 1 and `sck` = 1; right after reset `done` = 0 and `mosi` = 0.
- R2: A load strobe while idle captures the frame {8'h11, `tap_val`}. The frame is sent command byte first, each byte most significant bit first. The receiver takes each bit on a rising edge of `sck`.
- R3: A start pulse while idle, after a load, drives `cs_n` low from the next cycle on. `cs_n` stays low for exactly 33 clock cycles (counter values 32 down to 0).
- R4: Each frame carries exactly 16 rising edges of `sck`. `sck` is the inverse of the counter's least significant bit, so it is 1 in the first active cycle and then toggles every cycle.
- R5: `mosi` changes only in cycles where `sck` falls, so it holds steady across every rising edge of `sck`.
- R6: `done` is high for exactly one cycle per frame, in the first cycle in which `cs_n` is high again.
- R7: A start pulse while a frame is active has no effect on that frame's length, bits or completion.
- R8: A load strobe while a frame is active is ignored: the frame in flight keeps its bits and length.
- R9: A start pulse while the counter holds zero (no load since the last frame) is ignored, and `cs_n` stays high.
- R10: The counter's upper stage decrements only in cycles where all lower stages show zero. No stage changes while the run flag is clear, except on a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture the frame and preset the counter |
| tap_val | input | 8 | Tap value sent as the second byte |
| start | input | 1 | Begin sending the loaded frame |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock to the potentiometer |
| mosi | output | 1 | Serial data to the potentiometer |
| done | output | 1 | One-cycle pulse when chip select rises |

## Verification
The assertions check on every cycle the idle level of `sck`, the stability of `mosi` across each rising `sck` edge, the shape of the `done` pulse, and that `cs_n` stays low until the terminal count. They also check the per-stage decrement and the rule that a higher stage holds while a lower stage is nonzero. Only the bench's scenarios can show the overall results: the 16 received bits match the command and tap value for all 256 tap values, the frame lasts exactly 33 cycles, strobes during a frame leave it unchanged, and a start with an empty counter produces no frame.

// File: rtl/dcp_loader_pkg.sv
// Package: shared constants for the frame loader.
// Assumes frame = command byte then data byte.
package dcp_loader_pkg;
    localparam int CMD_W      = 8;
    localparam logic [CMD_W-1:0] CMD_WRITE = 8'h11;
    localparam int STAGE_W    = 4;
    localparam int N_STAGES   = 2;
endpackage

// File: rtl/dcp_stage_counter.sv
// Module: one loadable down-counting stage of the cascaded counter.
// Decrements (wrapping) when dec is high, load has priority.
// Flags its terminal count when it holds zero.
module dcp_stage_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] q,
    output logic         tc
);
    // Stage register: clear, preset or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (dec)   q <= q - W'(1);
    end

    // Terminal count when the stage is empty.
    assign tc = (q == '0);

    assert_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (q == $past(q) - W'(1)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(q));
endmodule

// File: rtl/dcp_frame_sreg.sv
// Module: parallel-in serial-out frame register.
// The frame is captured on load. On each tick the top bit moves to
// mosi and the register shifts left, so bits leave MSB first.
module dcp_frame_sreg #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               tick,
    output logic               mosi
);
    logic [FRAME_W-1:0] sreg;

    // Capture or shift the frame; present the outgoing bit on mosi.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            mosi <= 1'b0;
        end else if (load) begin
            sreg <= frame;
            mosi <= 1'b0;
        end else if (tick) begin
            mosi <= sreg[FRAME_W-1];
            sreg <= {sreg[FRAME_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/dcp_frame_loader.sv
// Module: top of the frame loader.
// A load preset the counter to twice the frame length. A start sets the
// run flag, which drives cs_n low and lets the cascaded counter step
// down. The counter LSB is the shift clock and sck is its inverse. The
// all-zero terminal count clears the flag and pulses done.
// Assumes load and start are single-cycle, synchronous strobes.
module dcp_frame_loader
    import dcp_loader_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tap_val,
    input  logic              start,
    output logic              cs_n,
    output logic              sck,
    output logic              mosi,
    output logic              done
);
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CNT_W   = STAGE_W * N_STAGES;
    localparam logic [CNT_W-1:0] PRESET = CNT_W'(2 * FRAME_W);

    logic                run;
    logic                ld_ok;
    logic                st_ok;
    logic                all_tc;
    logic                step;
    logic [N_STAGES-1:0] tc;
    logic [N_STAGES-1:0] sdec;
    logic [STAGE_W-1:0]  cq [N_STAGES];

    // Accept strobes only while no frame is active.
    assign ld_ok  = load && !run;
    assign all_tc = &tc;
    assign st_ok  = start && !run && !ld_ok && !all_tc;
    assign step   = run && !all_tc;

    // Ripple enable: a stage steps only when all lower stages are empty.
    always_comb begin
        for (int i = 0; i < N_STAGES; i++) begin
            sdec[i] = step;
            for (int j = 0; j < i; j++) sdec[i] = sdec[i] && tc[j];
        end
    end

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        dcp_stage_counter #(.W(STAGE_W)) i_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld_ok),
            .load_val (PRESET[g*STAGE_W +: STAGE_W]),
            .dec      (sdec[g]),
            .q        (cq[g]),
            .tc       (tc[g])
        );
    end

    // Run flag: set by an accepted start, cleared at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= run && all_tc;
            if (run && all_tc) run <= 1'b0;
            else if (st_ok)    run <= 1'b1;
        end
    end

    // Shift on each rising step of the counter LSB (even to odd).
    dcp_frame_sreg #(.FRAME_W(FRAME_W)) i_sreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_ok),
        .frame ({CMD_WRITE, tap_val}),
        .tick  (step && !cq[0][0]),
        .mosi  (mosi)
    );

    assign cs_n = !run;
    assign sck  = run ? !cq[0][0] : 1'b1;

    assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sck);
    assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));
    assert_done_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !all_tc) |=> !cs_n);
    if (N_STAGES > 1) begin : g_casc
        assert_upper_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_ok && !tc[0]) |=> $stable(cq[1]));
    end
endmodule

// File: tb/test_dcp_frame_loader.sv
module test_dcp_frame_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [7:0] tap_val = 8'h00;
    logic       start = 1'b0;
    logic       cs_n, sck, mosi, done;
    int         total = 0;
    int         bad = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    dcp_frame_loader i_dcp_frame_loader (
        .clk(clk), .rst_n(rst_n), .load(load), .tap_val(tap_val),
        .start(start), .cs_n(cs_n), .sck(sck), .mosi(mosi), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one frame; optionally strobe start and load mid-frame (R7, R8).
    task automatic frame(input logic [7:0] d, input bit inj);
        int low = 0, rises = 0, dones = 0, done_at = -1;
        logic [15:0] got = '0;
        logic prev = 1'b1;
        @(negedge clk) load = 1'b1; tap_val = d;
        @(negedge clk) load = 1'b0; start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 45; k++) begin
            if (!cs_n) low++;
            if (sck && !prev) begin rises++; got = {got[14:0], mosi}; end
            prev = sck;
            if (done) begin dones++; done_at = k; end
            if (inj && k == 5) begin start = 1'b1; load = 1'b1; tap_val = ~d; end
            else begin start = 1'b0; load = 1'b0; end
            @(negedge clk);
        end
        check(got == {8'h11, d}, inj ? "R2/R8" : "R2", got, {8'h11, d});
        check(low == 33, inj ? "R3/R7" : "R3", low, 33);
        check(rises == 16, "R4", rises, 16);
        check(dones == 1 && done_at == 33, "R6", done_at, 33);
        check(cs_n && sck, "R1", {cs_n, sck}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1 && sck == 1 && done == 0 && mosi == 0, "R1",
              {cs_n, sck, done, mosi}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 256; d++) frame(8'(d), (d % 16) == 5);
        // R9: start with an empty counter is ignored.
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            check(cs_n && sck && !done, "R9", {cs_n, sck, done}, 3'b110);
            @(negedge clk);
        end
        frame(8'hA5, 1'b0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule